// File: doc/BRIEF.md
# Serial configuration slave receiver

This block is the processor-driven alternative to loading the device configuration from a serial memory. When the source-select input is low, an external processor drives a serial clock and a serial data line, and the block shifts the bits into a file of 54 eight-bit configuration registers. Both serial lines cross into the system clock domain through two-flop synchronizers. Rising edges of the serial clock are detected in the system clock domain, and the data bit is captured on each edge.

The frame has a fixed length of 431 serial clocks. Register 0 is sent first, but its top bit is never clocked, so it takes seven bits, sent as bit 6 down to bit 0. Registers 1 through 53 follow, with eight bits each, sent most significant bit first. Once the last bit of register 53 has been stored, a ready output goes high and stays high. The rest of the device waits on this output before it starts. Serial edges that arrive after the frame is complete are ignored until the next reset.

Top module: `cfg_serial_slave`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `cfg_ready` is 0 and every bit of `cfg_regs` is 0.
- R2: While `proc_mode_n` is 1, serial clock edges have no effect: `cfg_ready` stays 0 and `cfg_regs` keeps its value.
- R3: With `proc_mode_n` at 0, `ser_dat` is captured on each rising edge of `ser_clk`. Within a register the bits arrive most significant first. Register n occupies `cfg_regs[8n+7:8n]`.
- R4: The first 7 rising edges load register 0 as bits 6 down to 0. Bit 7 of register 0 stays 0.
- R5: Registers 1 to 53 each take the next 8 rising edges, bit 7 first, and are filled in ascending order.
- R6: `cfg_ready` stays 0 until the 431st rising edge. It is 1 no later than 5 system clocks after that serial edge.
- R7: Rising edges after the 431st change neither `cfg_regs` nor `cfg_ready` until the next reset.
- R8: Once `cfg_ready` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_mode_n | input | 1 | 0 = processor drives the serial lines, 1 = this port is idle |
| ser_clk | input | 1 | Serial clock from the processor (asynchronous) |
| ser_dat | input | 1 | Serial data from the processor, valid around the rising edge of `ser_clk` |
| cfg_regs | output | 432 | Configuration file, with register n at bits 8n+7..8n |
| cfg_ready | output | 1 | High once the whole frame has been received |

## Verification
Two frames with different byte patterns are sent. The first pattern sets bit 7 of the byte offered for register 0, so a design that clocks that bit in, or that shifts the frame by one bit, gives wrong bytes in every register. The second pattern, sent after a reset, separates a correct reset from values left over from the first frame. The ready output is read after 430 edges and again after the 431st, which pins the frame length to the exact count. A full frame sent while the port is idle, and extra edges sent after ready, must both leave the register file and the ready output unchanged.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  parameter int unsigned CFG_NREG  = 54;
  parameter int unsigned CFG_BW    = 8;
  parameter int unsigned CFG_SKIP0 = 1;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_a,
  input  logic sdat_a,
  output logic sdat_s,
  output logic sclk_rise
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], sclk_a};
      dat_pipe <= {dat_pipe[STAGES-2:0], sdat_a};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign sclk_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign sdat_s    = dat_pipe[STAGES-1];

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/cfgs_frame_ctr.sv
module cfgs_frame_ctr #(
  parameter int unsigned NREG  = 54,
  parameter int unsigned BW    = 8,
  parameter int unsigned SKIP0 = 1,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned BIW  = $clog2(BW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  output logic [RW-1:0]  reg_idx,
  output logic [BIW-1:0] bit_idx,
  output logic           byte_done,
  output logic           done
);
  localparam logic [BIW-1:0] TOP_BIT   = BIW'(BW-1);
  localparam logic [BIW-1:0] FIRST_BIT = BIW'(BW-1-SKIP0);
  localparam logic [RW-1:0]  LAST_REG  = RW'(NREG-1);

  logic adv;
  assign adv       = step & ~done;
  assign byte_done = adv & (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_idx <= '0;
      bit_idx <= FIRST_BIT;
      done    <= 1'b0;
    end else if (adv) begin
      if (bit_idx == '0) begin
        bit_idx <= TOP_BIT;
        if (reg_idx == LAST_REG) done <= 1'b1;
        else reg_idx <= reg_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(reg_idx) == LAST_REG && $past(bit_idx) == '0));
  // R7
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(reg_idx) && $stable(bit_idx) && done));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgs_pkg::*;
#(
  parameter int unsigned NREG   = CFG_NREG,
  parameter int unsigned BW     = CFG_BW,
  parameter int unsigned SKIP0  = CFG_SKIP0,
  parameter int unsigned STAGES = 2,
  localparam int unsigned RW    = $clog2(NREG),
  localparam int unsigned BIW   = $clog2(BW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             proc_mode_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [NREG*BW-1:0] cfg_regs,
  output logic             cfg_ready
);
  logic           dat_s, rise, step, byte_done, done;
  logic [RW-1:0]  reg_idx;
  logic [BIW-1:0] bit_idx;
  logic [BW-1:0]  shreg;
  logic [BW-1:0]  new_byte;
  logic [BW-1:0]  rf [NREG];

  cfgs_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_a(ser_clk), .sdat_a(ser_dat),
    .sdat_s(dat_s), .sclk_rise(rise)
  );

  assign step = rise & ~proc_mode_n;

  cfgs_frame_ctr #(.NREG(NREG), .BW(BW), .SKIP0(SKIP0)) u_ctr (
    .clk(clk), .rst(rst), .step(step), .reg_idx(reg_idx),
    .bit_idx(bit_idx), .byte_done(byte_done), .done(done)
  );

  assign new_byte = {shreg[BW-2:0], dat_s};

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (step && !done) shreg <= new_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (byte_done) begin
      rf[reg_idx] <= new_byte;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_out
      assign cfg_regs[g*BW +: BW] = rf[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cfg_ready <= 1'b0;
    else     cfg_ready <= done;
  end

  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> cfg_ready);
  // R2
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    proc_mode_n |=> $stable(cfg_regs));
  // R4
  reg0_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_regs[BW-1]);
endmodule

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
  localparam int NREG = 54;
  localparam int NBITS = 431;

  logic clk = 1'b0, rst = 1'b1, mode_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [NREG*8-1:0] regs;
  logic ready;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_slave u0 (
    .clk(clk), .rst(rst), .proc_mode_n(mode_n), .ser_clk(sclk),
    .ser_dat(sdat), .cfg_regs(regs), .cfg_ready(ready)
  );

  function automatic logic [7:0] pat(int sel, int r);
    if (sel == 0) return 8'((r * 37) + 8'h9C);
    return 8'h5A ^ 8'(r);
  endfunction

  function automatic logic bit_at(int sel, int k);
    logic [7:0] b;
    if (k < 7) begin
      b = pat(sel, 0);
      return b[6-k];
    end
    b = pat(sel, 1 + (k - 7) / 8);
    return b[7 - ((k - 7) % 8)];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_range(int sel, int from, int to);
    for (int k = from; k <= to; k++) begin
      sdat = (k < NBITS) ? bit_at(sel, k) : 1'b1;
      idle(4);
      sclk = 1'b1;
      idle(8);
      sclk = 1'b0;
      idle(4);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic check_file(string req, int sel, bit zero);
    for (int r = 0; r < NREG; r++) begin
      logic [7:0] e;
      e = zero ? 8'h00 : pat(sel, r);
      if (r == 0) e[7] = 1'b0;
      chk(req, 32'(regs[r*8 +: 8]), 32'(e));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(2);
    chk("R1 ready in reset", 32'(ready), 0);
    rst = 1'b0;
    idle(1);
    chk("R1 ready after reset", 32'(ready), 0);
    check_file("R1 file clear", 0, 1'b1);
  endtask

  task automatic t_idle_mode();
    mode_n = 1'b1;
    send_range(0, 0, NBITS - 1);
    idle(10);
    chk("R2 ready idle", 32'(ready), 0);
    check_file("R2 file unchanged", 0, 1'b1);
  endtask

  task automatic t_frame_a();
    mode_n = 1'b0;
    send_range(0, 0, NBITS - 2);
    idle(10);
    chk("R6 ready low at 430", 32'(ready), 0);
    sdat = bit_at(0, NBITS - 1);
    idle(4);
    sclk = 1'b1;
    idle(5);
    chk("R6 ready after 431", 32'(ready), 1);
    idle(3);
    sclk = 1'b0;
    idle(4);
    chk("R4 reg0 bit7 zero", 32'(regs[7]), 0);
    check_file("R3 R4 R5 frame A", 0, 1'b0);
  endtask

  task automatic t_extra();
    send_range(1, 0, 20);
    idle(10);
    chk("R7 R8 ready held", 32'(ready), 1);
    check_file("R7 file frozen", 0, 1'b0);
  endtask

  task automatic t_frame_b();
    do_reset();
    chk("R1 ready cleared", 32'(ready), 0);
    check_file("R1 file cleared", 1, 1'b1);
    send_range(1, 0, NBITS - 1);
    idle(10);
    chk("R6 ready frame B", 32'(ready), 1);
    check_file("R3 R5 frame B", 1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_mode();
    t_frame_a();
    t_extra();
    t_frame_b();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule